// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Command Capture

This block holds the bytes that a SCSI host adapter moves under programmed I/O. A host register write to the FIFO address pushes one byte and a register read pops one. A write pointer, a read pointer and a signed byte count track the contents. The write side accepts at most one entry fewer than the storage depth. Whenever a read leaves the two pointers equal, both return to zero, so each drained burst starts again at entry zero.

While command capture is active, host writes bypass the FIFO and are appended to a separate command buffer with its own length counter. A neighbouring command decoder reads that buffer by index. A response-load strobe places a two-byte status reply (the status byte, then zero) at the head of the FIFO, sets a flags value of 2 and raises the interrupt. A pointer-clear strobe, used when a command is taken or a selection starts, empties the FIFO. Bus phase control lies outside this block. Its only input on that subject is a flag saying whether the bus is in a data-in phase.

Top module: `pio_fifo`

## Requirements
- R1: After reset the count, command length, interrupt, flags and read data are all zero.
- R2: A write with command capture off and no higher-priority strobe stores the byte at the write pointer, advances the pointer and adds one to the count.
- R3: A data write is dropped when the write pointer already equals DEPTH-1. The FIFO therefore holds at most DEPTH-1 bytes, and the count stays at DEPTH-1.
- R4: A read in the data-in phase with the read pointer behind the write pointer returns the oldest byte one cycle later, subtracts one from the count and raises the interrupt.
- R5: A read with the data-in flag low returns 0x00 and raises the interrupt, and the count is left unchanged.
- R6: A read in the data-in phase on an empty FIFO leaves the read data, the count and the interrupt unchanged.
- R7: After any read that leaves the read and write pointers equal, both become zero, so the full DEPTH-1 capacity is available again.
- R8: A write with command capture on appends the byte to the command buffer at index cmd_len and adds one to cmd_len, and the FIFO count is left unchanged. cmd_clr sets cmd_len to zero and takes priority over a command write in the same cycle.
- R9: A command write is dropped once cmd_len equals CMD_DEPTH.
- R10: A response load sets the count to 2, the flags to 2, the read pointer to 0 and the write pointer to 2, and raises the interrupt. The next two data-in reads return the status byte and then 0x00, and the FIFO is empty after them.
- R11: A pointer clear sets the count and both pointers to zero.
- R12: irq_clr lowers the interrupt. A raising event in the same cycle wins.
- R13: When strobes coincide, the priority is response load, then pointer clear, then read, then write. A write that coincides with any of the other three is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write to the FIFO address |
| wr_data | input | 8 | Byte being written |
| rd_en | input | 1 | Host read of the FIFO address |
| cmd_mode | input | 1 | Command capture active |
| cmd_clr | input | 1 | Zero the command length |
| rsp_load | input | 1 | Load the two-byte status reply |
| rsp_status | input | 8 | Status byte of the reply |
| ptr_clr | input | 1 | Empty the FIFO (command taken or selection start) |
| data_in_phase | input | 1 | Bus is in a data-in phase |
| irq_clr | input | 1 | Lower the interrupt |
| cmd_idx | input | $clog2(CMD_DEPTH) | Command buffer read index |
| rd_data | output | 8 | Byte returned by the last read |
| irq | output | 1 | Interrupt request |
| count | output | $clog2(DEPTH)+2 | Signed byte count |
| cmd_len | output | $clog2(CMD_DEPTH+1) | Command bytes captured |
| cmd_byte | output | 8 | Command buffer entry at cmd_idx |
| flags | output | 8 | Flags value, set to 2 by a response load |

## Verification
A wrong pointer in this block stays hidden until a read reaches it. A write pointer that fails to stop at DEPTH-1 shows up in the count on the cycle after the extra write. A read pointer that does not snap back shows up only after a later refill: the FIFO then refuses bytes early, or returns stale bytes, on the first read past the point where the snap was missed. Command-buffer faults are visible at once through cmd_len, and through cmd_byte as soon as the index is applied. The stimulus therefore mixes long random runs with drain-then-refill sequences, so that pointer errors reach the ports within one burst.

// File: rtl/pio_fifo.sv
module pio_fifo #(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 32,
  parameter int RSP_FLAGS = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [7:0]                       wr_data,
  input  logic                             rd_en,
  input  logic                             cmd_mode,
  input  logic                             cmd_clr,
  input  logic                             rsp_load,
  input  logic [7:0]                       rsp_status,
  input  logic                             ptr_clr,
  input  logic                             data_in_phase,
  input  logic                             irq_clr,
  input  logic [$clog2(CMD_DEPTH)-1:0]     cmd_idx,
  output logic [7:0]                       rd_data,
  output logic                             irq,
  output logic signed [$clog2(DEPTH)+1:0]  count,
  output logic [$clog2(CMD_DEPTH+1)-1:0]   cmd_len,
  output logic [7:0]                       cmd_byte,
  output logic [7:0]                       flags
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = PTR_W + 2;
  localparam int CLEN_W = $clog2(CMD_DEPTH + 1);
  localparam logic [PTR_W-1:0]  STOP_AT = PTR_W'(DEPTH - 1);
  localparam logic [CLEN_W-1:0] CMD_MAX = CLEN_W'(CMD_DEPTH);

  logic [7:0]       mem     [DEPTH];
  logic [7:0]       cmd_mem [CMD_DEPTH];
  logic [PTR_W-1:0] rptr, wptr, rptr_inc;
  logic             go_rsp, go_clr, go_rd, go_wr;
  logic             dat_wr, cmd_wr, rd_hit, snap, irq_set;

  assign go_rsp   = rsp_load;
  assign go_clr   = !rsp_load && ptr_clr;
  assign go_rd    = !rsp_load && !ptr_clr && rd_en;
  assign go_wr    = !rsp_load && !ptr_clr && !rd_en && wr_en;
  assign dat_wr   = go_wr && !cmd_mode && (wptr != STOP_AT);
  assign cmd_wr   = go_wr && cmd_mode && !cmd_clr && (cmd_len < CMD_MAX);
  assign rd_hit   = go_rd && data_in_phase && (rptr < wptr);
  assign rptr_inc = rptr + PTR_W'(rd_hit);
  assign snap     = go_rd && (rptr_inc == wptr);
  assign irq_set  = go_rsp || (go_rd && (!data_in_phase || rd_hit));
  assign cmd_byte = cmd_mem[cmd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
      flags <= '0;
    end else if (go_rsp) begin
      rptr  <= '0;
      wptr  <= PTR_W'(2);
      count <= CNT_W'(2);
      flags <= 8'(RSP_FLAGS);
    end else if (go_clr) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else if (go_rd) begin
      if (snap) begin
        rptr <= '0;
        wptr <= '0;
      end else begin
        rptr <= rptr_inc;
      end
      if (rd_hit) count <= count - CNT_W'(1);
    end else if (dat_wr) begin
      wptr  <= wptr + PTR_W'(1);
      count <= count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (go_rsp) begin
      mem[0] <= rsp_status;
      mem[1] <= 8'h00;
    end else if (dat_wr) begin
      mem[wptr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        rd_data <= '0;
    else if (go_rd && !data_in_phase)  rd_data <= '0;
    else if (rd_hit)                   rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cmd_len <= '0;
    else if (cmd_clr) cmd_len <= '0;
    else if (cmd_wr)  cmd_len <= cmd_len + CLEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (cmd_wr) cmd_mem[cmd_len[$clog2(CMD_DEPTH)-1:0]] <= wr_data;
  end
endmodule

// File: rtl/pio_fifo_chk.sv
module pio_fifo_chk #(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            wr_en,
  input logic                            rd_en,
  input logic                            cmd_mode,
  input logic                            cmd_clr,
  input logic                            rsp_load,
  input logic                            ptr_clr,
  input logic                            data_in_phase,
  input logic [7:0]                      rd_data,
  input logic                            irq,
  input logic signed [$clog2(DEPTH)+1:0] count,
  input logic [$clog2(CMD_DEPTH+1)-1:0]  cmd_len,
  input logic [$clog2(DEPTH)-1:0]        rptr,
  input logic [$clog2(DEPTH)-1:0]        wptr
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CLEN_W = $clog2(CMD_DEPTH + 1);

  logic quiet;
  assign quiet = !rsp_load && !ptr_clr;

  assert_overrun_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !rd_en && wr_en && !cmd_mode && wptr == PTR_W'(DEPTH - 1)) |=> $stable(count));

  assert_dataout_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && rd_en && !data_in_phase) |=> (rd_data == 8'h00 && irq));

  assert_snap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && rd_en) |=> (rptr != wptr || (rptr == '0 && wptr == '0)));

  assert_cmd_append_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !rd_en && wr_en && cmd_mode && !cmd_clr && cmd_len < CLEN_W'(CMD_DEPTH))
    |=> cmd_len == $past(cmd_len) + CLEN_W'(1));

  assert_cmd_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_clr && cmd_len == CLEN_W'(CMD_DEPTH)) |=> $stable(cmd_len));

  assert_rsp_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_load |=> (count == 2 && rptr == '0 && wptr == PTR_W'(2) && irq));

  assert_ptr_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_load && ptr_clr) |=> (count == 0 && rptr == '0 && wptr == '0));
endmodule

bind pio_fifo pio_fifo_chk #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH)) u_chk (.*);

// File: tb/pio_fifo_bench.sv
module pio_fifo_bench;
  localparam int DEPTH = 16;
  localparam int CMDD  = 32;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, cmd_mode = 0, cmd_clr = 0, rsp_load = 0;
  logic ptr_clr = 0, data_in_phase = 0, irq_clr = 0;
  logic [7:0] wr_data = 0, rsp_status = 0;
  logic [4:0] cmd_idx = 0;
  logic [7:0] rd_data, cmd_byte, flags;
  logic irq;
  logic signed [5:0] count;
  logic [5:0] cmd_len;

  pio_fifo u_pio_fifo (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [7:0] m_buf [DEPTH];
  logic [7:0] m_cmd [CMDD];
  int m_r, m_w, m_cnt, m_clen, m_flags;
  logic [7:0] m_rd;
  bit m_irq;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_r = 0; m_w = 0; m_cnt = 0; m_clen = 0; m_flags = 0; m_rd = 0; m_irq = 0;
  endfunction

  function automatic void model_step(bit wr, bit rd, bit cm, bit cc, bit rl, bit pc,
                                     bit ph, bit ic, logic [7:0] wd, logic [7:0] st);
    bit set = 0;
    if (rl) begin
      m_buf[0] = st; m_buf[1] = 0; m_r = 0; m_w = 2; m_cnt = 2; m_flags = 2; set = 1;
    end else if (pc) begin
      m_r = 0; m_w = 0; m_cnt = 0;
    end else if (rd) begin
      if (!ph) begin m_rd = 0; set = 1; end
      else if (m_r < m_w) begin m_rd = m_buf[m_r]; m_r++; m_cnt--; set = 1; end
      if (m_r == m_w) begin m_r = 0; m_w = 0; end
    end else if (wr && !cm && m_w != DEPTH - 1) begin
      m_buf[m_w] = wd; m_w++; m_cnt++;
    end
    if (cc) m_clen = 0;
    else if (wr && cm && !rl && !pc && !rd && m_clen < CMDD) begin
      m_cmd[m_clen] = wd; m_clen++;
    end
    if (set) m_irq = 1; else if (ic) m_irq = 0;
  endfunction

  task automatic cyc(string req, bit wr, bit rd, bit cm, bit cc, bit rl, bit pc,
                     bit ph, bit ic, logic [7:0] wd, logic [7:0] st);
    @(negedge clk);
    wr_en = wr; rd_en = rd; cmd_mode = cm; cmd_clr = cc; rsp_load = rl;
    ptr_clr = pc; data_in_phase = ph; irq_clr = ic; wr_data = wd; rsp_status = st;
    @(posedge clk);
    model_step(wr, rd, cm, cc, rl, pc, ph, ic, wd, st);
    #2;
    chk(req, "count", int'(count), m_cnt);
    chk(req, "irq", int'(irq), int'(m_irq));
    chk(req, "rd_data", int'(rd_data), int'(m_rd));
    chk(req, "cmd_len", int'(cmd_len), m_clen);
    chk(req, "flags", int'(flags), m_flags);
  endtask

  task automatic idle();
    cyc("R13", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    chk("WATCHDOG", "timeout", 1, 0);
    if (!finished) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "count", int'(count), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "cmd_len", int'(cmd_len), 0);
    chk("R1", "flags", int'(flags), 0);
    chk("R1", "rd_data", int'(rd_data), 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < DEPTH; i++) cyc("R2", 1, 0, 0, 0, 0, 0, 1, 0, 8'hA0 + 8'(i), 0);
    chk("R3", "count_full", int'(count), DEPTH - 1);
    cyc("R3", 1, 0, 0, 0, 0, 0, 1, 0, 8'h55, 0);
    chk("R3", "count_after_overrun", int'(count), DEPTH - 1);

    for (int i = 0; i < DEPTH - 1; i++) begin
      cyc("R4", 0, 1, 0, 0, 0, 0, 1, 0, 0, 0);
      chk("R4", "byte_order", int'(rd_data), 'hA0 + i);
    end
    chk("R7", "drained_count", int'(count), 0);
    for (int i = 0; i < DEPTH; i++) cyc("R7", 1, 0, 0, 0, 0, 0, 1, 0, 8'h30 + 8'(i), 0);
    chk("R7", "refill_capacity", int'(count), DEPTH - 1);

    cyc("R5", 0, 1, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R5", "dataout_zero", int'(rd_data), 0);
    chk("R5", "count_kept", int'(count), DEPTH - 1);

    cyc("R11", 0, 0, 0, 0, 0, 1, 1, 1, 0, 0);
    chk("R11", "count_zero", int'(count), 0);
    cyc("R12", 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    chk("R12", "irq_low", int'(irq), 0);
    cyc("R6", 0, 1, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R6", "empty_irq", int'(irq), 0);
    chk("R6", "empty_rd_data", int'(rd_data), 0);

    for (int i = 0; i < CMDD + 2; i++) cyc("R8", 1, 0, 1, 0, 0, 0, 1, 0, 8'hC0 + 8'(i), 0);
    chk("R9", "cmd_len_cap", int'(cmd_len), CMDD);
    chk("R8", "count_untouched", int'(count), 0);
    for (int i = 0; i < CMDD; i += 7) begin
      cmd_idx = 5'(i); #1;
      chk("R8", "cmd_byte", int'(cmd_byte), 'hC0 + i);
    end
    cyc("R8", 1, 0, 1, 1, 0, 0, 1, 0, 8'h11, 0);
    chk("R8", "cmd_clr_wins", int'(cmd_len), 0);

    cyc("R10", 0, 0, 0, 0, 1, 0, 1, 0, 0, 8'h02);
    chk("R10", "rsp_count", int'(count), 2);
    chk("R10", "rsp_flags", int'(flags), 2);
    cyc("R10", 0, 1, 0, 0, 0, 0, 1, 1, 0, 0);
    chk("R10", "status_byte", int'(rd_data), 2);
    chk("R12", "set_wins", int'(irq), 1);
    cyc("R10", 0, 1, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R10", "zero_byte", int'(rd_data), 0);
    chk("R10", "empty_after", int'(count), 0);

    cyc("R13", 1, 0, 0, 0, 1, 1, 1, 0, 8'h77, 8'h3C);
    chk("R13", "rsp_over_clr", int'(count), 2);
    cyc("R13", 1, 1, 0, 0, 0, 0, 1, 0, 8'h77, 0);
    chk("R13", "write_ignored", int'(count), 1);

    for (int i = 0; i < 4000; i++) begin
      int p = $urandom_range(0, 99);
      cyc("R13", p < 40, p >= 40 && p < 75, $urandom_range(0, 9) == 0,
          $urandom_range(0, 30) == 0, p >= 97, p >= 94 && p < 97,
          $urandom_range(0, 3) != 0, $urandom_range(0, 4) == 0,
          8'($urandom), 8'($urandom));
      if (i % 50 == 0) begin
        cmd_idx = 5'($urandom_range(0, CMDD - 1)); #1;
        if (int'(cmd_idx) < m_clen) chk("R8", "rand_cmd_byte", int'(cmd_byte), int'(m_cmd[cmd_idx]));
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule